// File: doc/BRIEF.md
# Token-Ring Depth-Expansion FIFO Cell

This block is one slice of a first-in first-out buffer that is made deeper by placing identical slices in a ring. Every slice sees the same write strobe, read strobe and write data. Each slice has a single link output that feeds the link input of the next slice, and the last slice feeds the first. The ring needs no logic between slices apart from an OR of the per-slice read data and an OR of the per-slice flags.

Two tokens travel round the ring. The write token marks the slice that stores the next incoming word. The read token marks the slice that presents the oldest word. A slice hands a token on when its own pointer leaves its last location. The handoff is a one-cycle pulse on the link, raised in the cycle of that write or read. The receiving slice tells the two tokens apart by which strobe is active in that cycle, so the chain never raises both strobes in the same cycle. Reads are show-ahead: the token holder presents its oldest word continuously, and the read strobe removes that word.

Top module: `chain_fifo_cell`

## Requirements
- R1: In the first cycle after reset, the slice whose `first_n` is low holds both tokens. It reports `empty_o` = 1, `full_o` = 0 and `rvalid_o` = 0. Every other slice reports `empty_o` = 0, `full_o` = 0 and `rvalid_o` = 0.
- R2: Only the slice holding the write token stores `wdata_i` on a write, at its write pointer, which then advances. A write to location DEPTH-1 raises `link_out_o` during that same cycle, for that cycle only, and gives up the write token. The write and read strobes are never high together.
- R3: A slice whose `link_in_i` is high in a cycle where `wr_i` is high takes the write token. Its next write lands at its current write pointer.
- R4: The read-token holder with data raises `rvalid_o` and drives its oldest word on `rdata_o`. A read removes that word. A read from location DEPTH-1 raises `link_out_o` for that cycle and hands the read token to the next slice.
- R5: A slice without the read token, or with the read token but no data, drives `rvalid_o` = 0 and `rdata_o` = 0. The chain output is therefore the OR of all slices' `rdata_o`.
- R6: `full_o` is high when the slice holds the write token and has no free location. A token that arrives at a full slice stays there pending. While `full_o` is high, writes are refused and stored contents are unchanged. `full_o` clears once a read frees a location in that slice.
- R7: `empty_o` is high when the slice holds the read token and holds no data. A read in that state changes nothing.
- R8: A ring of N slices behaves as one FIFO of N*DEPTH words. The ORs of `full_o` and of `empty_o` equal "N*DEPTH words stored" and "no words stored". Words leave in the order they were written, including across slice boundaries and after wrapping round the ring.
- R9: While `rst_n` is low, strobes have no effect. On release, all pointers are zero and the tokens are placed as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| first_n | input | 1 | Low on exactly one slice of the ring: that slice starts with both tokens |
| wr_i | input | 1 | Chain write strobe, gated outside by composite full |
| wdata_i | input | DW | Write data |
| rd_i | input | 1 | Chain read strobe, gated outside by composite empty |
| link_in_i | input | 1 | Token pulse from the previous slice |
| link_out_o | output | 1 | Token pulse to the next slice |
| rdata_o | output | DW | Oldest word when this slice has valid read data, else zero |
| rvalid_o | output | 1 | This slice holds the read token and has data |
| full_o | output | 1 | This slice holds the write token and has no free location |
| empty_o | output | 1 | This slice holds the read token and has no data |

## Verification
A token held by the wrong slice is usually invisible at first. It shows up one slice-depth later, either as a link pulse from the wrong slice or as data returned out of order when the read token reaches the affected slice. The bench therefore drives a three-slice ring whose first slice is not slice 0. It checks link pulses in the exact cycle of each last-location access. It also fills, overflows, wraps and drains the whole ring, so that a counting or pointer error reaches the composite flags or the read data within at most one full ring of traffic.

// File: rtl/chain_fifo_cell.sv
module chain_fifo_cell #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          link_in_i,
  output logic          link_out_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          wr_tok, rd_tok;
  logic          wr_do, rd_do, wr_pass, rd_pass;

  assign wr_do   = wr_tok && wr_i && (cnt != CAP);
  assign rd_do   = rd_tok && rd_i && (cnt != '0);
  assign wr_pass = wr_do && (wptr == LAST);
  assign rd_pass = rd_do && (rptr == LAST);

  assign link_out_o = wr_pass || rd_pass;
  assign full_o     = wr_tok && (cnt == CAP);
  assign empty_o    = rd_tok && (cnt == '0);
  assign rvalid_o   = rd_tok && (cnt != '0);
  assign rdata_o    = rvalid_o ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (wr_do) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      wr_tok <= !first_n;
      rd_tok <= !first_n;
    end else begin
      if (wr_do) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_do) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(wr_do) - CW'(rd_do);
      if (link_in_i && wr_i)      wr_tok <= 1'b1;
      else if (wr_pass)           wr_tok <= 1'b0;
      if (link_in_i && rd_i)      rd_tok <= 1'b1;
      else if (rd_pass)           rd_tok <= 1'b0;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && rd_i)); // R2
  AST_WR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (link_in_i && wr_i) |=> wr_tok); // R3
  AST_RD_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pass && !link_in_i) |=> !rvalid_o && !empty_o); // R4
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_i) |=> full_o && $stable(wptr) && $stable(cnt)); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && rd_i) |=> empty_o && $stable(rptr)); // R7
endmodule

// File: tb/chain_fifo_cell_tb_top.sv
module chain_fifo_cell_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int NC = 3;
  localparam int CAPT = NC * DEPTH;
  localparam logic [NC-1:0] FIRST_N = 3'b101;
  localparam int NV = 20;
  localparam logic [9:0] VEC [NV] = '{
    {2'b01, 8'h10}, {2'b01, 8'h11}, {2'b01, 8'h12}, {2'b10, 8'h00},
    {2'b01, 8'h13}, {2'b01, 8'h14}, {2'b10, 8'h00}, {2'b10, 8'h00},
    {2'b01, 8'h15}, {2'b01, 8'h16}, {2'b01, 8'h17}, {2'b10, 8'h00},
    {2'b01, 8'h18}, {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h00},
    {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b01, 8'h19}
  };

  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [DW-1:0] wdata = '0;
  logic [NC-1:0] link, full, empty, rvalid;
  logic [DW-1:0] rdata [NC];
  logic [DW-1:0] rdata_c;
  logic full_c, empty_c;
  int checks = 0, errs = 0;
  logic [DW-1:0] q [$];

  always #4 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_ring
    localparam int PREV = (g + NC - 1) % NC;
    if (g == 1) begin : g_dut
      chain_fifo_cell #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .first_n(FIRST_N[g]), .wr_i(wr), .wdata_i(wdata),
        .rd_i(rd), .link_in_i(link[PREV]), .link_out_o(link[g]), .rdata_o(rdata[g]),
        .rvalid_o(rvalid[g]), .full_o(full[g]), .empty_o(empty[g]));
    end else begin : g_peer
      chain_fifo_cell #(.DW(DW), .DEPTH(DEPTH)) cell_i (
        .clk(clk), .rst_n(rst_n), .first_n(FIRST_N[g]), .wr_i(wr), .wdata_i(wdata),
        .rd_i(rd), .link_in_i(link[PREV]), .link_out_o(link[g]), .rdata_o(rdata[g]),
        .rvalid_o(rvalid[g]), .full_o(full[g]), .empty_o(empty[g]));
    end
  end

  always_comb begin
    rdata_c = '0;
    for (int i = 0; i < NC; i++) rdata_c = rdata_c | rdata[i];
    full_c  = |full;
    empty_c = |empty;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [DW-1:0] d);
    wr = w; rd = r; wdata = d;
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic op_link(input logic w, input logic r, input logic [DW-1:0] d,
                         input logic [NC-1:0] exp, input string req);
    wr = w; rd = r; wdata = d;
    #1 check(req, link, exp);
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic write_m(input logic [DW-1:0] d);
    if (q.size() < CAPT) q.push_back(d);
    op(1, 0, d);
  endtask

  task automatic read_m(input string req);
    if (q.size() > 0) begin
      check(req, rdata_c, q[0]);
      void'(q.pop_front());
    end else begin
      check({req, " empty read data"}, rdata_c, 0);
    end
    op(0, 1, '0);
  endtask

  task automatic flags_m(input string req);
    check({req, " full"}, full_c, q.size() == CAPT);
    check({req, " empty"}, empty_c, q.size() == 0);
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    check("R1 empty per cell", empty, 3'b010);
    check("R1 full per cell", full, 3'b000);
    check("R1 rvalid", rvalid, 3'b000);
    check("R5 idle rdata", rdata_c, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][9:8] == 2'b01) write_m(VEC[i][7:0]);
      else read_m("R8 vector read");
      flags_m("R8 vector flags");
    end

    // R9: strobes during reset are ignored, state cleared
    rst_n = 0;
    op(1, 0, 8'hEE);
    op(0, 1, 8'h00);
    rst_n = 1;
    q.delete();
    check("R9 empty after reset", empty, 3'b010);
    check("R9 rvalid after reset", rvalid, 3'b000);

    for (int i = 0; i < DEPTH - 1; i++) begin
      q.push_back(DW'(8'h40 + i));
      op_link(1, 0, DW'(8'h40 + i), 3'b000, "R2 no early pulse");
    end
    q.push_back(8'h43);
    op_link(1, 0, 8'h43, 3'b010, "R2 pulse on last location");
    check("R4 read-token holder valid", rvalid, 3'b010);
    check("R5 other cells zero", rdata[0] | rdata[2], 0);
    for (int i = DEPTH; i < 2 * DEPTH - 1; i++) begin
      q.push_back(DW'(8'h40 + i));
      op(1, 0, DW'(8'h40 + i));
    end
    q.push_back(8'h47);
    op_link(1, 0, 8'h47, 3'b100, "R3 next cell took write token");
    for (int i = 2 * DEPTH; i < CAPT - 1; i++) begin
      q.push_back(DW'(8'h40 + i));
      op(1, 0, DW'(8'h40 + i));
    end
    q.push_back(8'h4B);
    op_link(1, 0, 8'h4B, 3'b001, "R3 wrap pulse to first cell");
    check("R6 pending token makes first cell full", full, 3'b010);
    op(1, 0, 8'hAA);
    flags_m("R6 refused write");
    check("R4 oldest word", rdata_c, 8'h40);
    read_m("R4 read");
    check("R6 full clears after read", full_c, 0);
    write_m(8'h99);
    flags_m("R8 wrapped fill");
    check("R6 full again", full, 3'b010);

    for (int i = 0; i < CAPT; i++) begin
      if (i == DEPTH - 2) begin
        check("R4 read pass data", rdata_c, q[0]);
        void'(q.pop_front());
        op_link(0, 1, '0, 3'b010, "R4 read token pulse");
      end else begin
        read_m("R8 drain order");
      end
    end
    flags_m("R8 drained");
    check("R7 empty holder cell", empty, 3'b010);
    op(0, 1, '0);
    check("R7 read on empty ignored", rdata_c, 0);
    check("R7 still empty", empty, 3'b010);
    write_m(8'h77);
    check("R7 pointer intact", rdata_c, 8'h77);
    read_m("R8 final read");
    flags_m("R8 final flags");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule